// File: doc/BRIEF.md
# Non-Maskable Interrupt Recognizer

This block turns an external non-maskable interrupt line into exactly one recognition event for the execution core. A rising edge on the line sets a single pending flag. The core sees the request only at an instruction boundary that it signals. At that point the block issues a one-cycle take pulse that carries the fixed vector number 02h. No acknowledge cycle and no vector fetch are involved.

A recognized request marks a handler as active. Further edges are then held pending until the core reports that the handler's return instruction has completed. While system-management mode is being entered or is active, recognition is suppressed. An edge caught during that period is kept and delivered after the exit strobe. No software mask input exists, so only the handler state and system-management mode can hold a request back.

A parameter chooses how the line is driven. In synchronous mode a one-clock high pulse is enough. In asynchronous mode a two-flop synchronizer sits in front of the edge detector. The line must then be low for two clocks and high for two clocks.

The recognition state machine has four states:
- `ST_READY`: no handler running, not in system-management mode.
- `ST_HANDLER`: a handler is running.
- `ST_SMM_IDLE`: in system-management mode, no handler running.
- `ST_SMM_HANDLER`: in system-management mode with a handler still running.

Its transitions are:
- READY→HANDLER on a take.
- READY→SMM_IDLE on enter.
- HANDLER→READY on return.
- HANDLER→SMM_HANDLER on enter, or HANDLER→SMM_IDLE when enter and return come in the same cycle.
- SMM_IDLE→READY on exit.
- SMM_HANDLER→SMM_IDLE on return.
- SMM_HANDLER→HANDLER on exit.
- SMM_HANDLER→READY when return and exit come in the same cycle.

Top module: `nmi_recognizer`

## Requirements
- R1: A rising edge on the line (after the synchronizer in asynchronous mode) sets the pending flag. A line held high produces no further edge.
- R2: A pending request is acted on only in a cycle with `insn_boundary` high while in ST_READY. `take_nmi` is then high for exactly the following cycle, and the pending flag clears.
- R3: `take_vector` reads 02h in the cycle `take_nmi` is high and 00h in every other cycle.
- R4: `handler_active` rises with `take_nmi` and falls in the cycle after `handler_return`. While it is high, instruction boundaries cause no take.
- R5: An edge seen while a handler runs stays pending. It is delivered at the first boundary after the return.
- R6: Only one request is held. Any number of edges before a take yield exactly one take.
- R7: While in system-management mode no take occurs. `smm_enter` overrides a boundary in the same cycle.
- R8: `smm_exit` lifts the mask. An edge latched while masked is delivered at the next boundary after the exit.
- R9: If system-management mode is entered while a handler runs, a return inside the mode clears the handler. An exit without a return restores the handler state.
- R10: An edge in the same cycle as a take leaves a new request pending.
- R11: In synchronous mode a one-clock pulse is recognized. In asynchronous mode a line that is low for two clocks and then high for two clocks gives one take 4 cycles after it first goes high, provided the boundary is held high.
- R12: While reset is held, and after it is released, `take_nmi` is 0, `take_vector` is 0, `handler_active` is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_line | input | 1 | External non-maskable interrupt line |
| insn_boundary | input | 1 | High in a cycle that ends an instruction |
| handler_return | input | 1 | High when the handler's return instruction completes |
| smm_enter | input | 1 | Strobe: system-management mode entered |
| smm_exit | input | 1 | Strobe: system-management mode left |
| take_nmi | output | 1 | One-cycle recognition pulse |
| take_vector | output | 8 | Vector number, valid with take_nmi |
| handler_active | output | 1 | A handler is running |

## Verification
The in-RTL assertions check on every cycle the following local rules:
- An edge always sets the pending flag, and the flag is kept until it is consumed.
- A take only follows a boundary with a request pending.
- The take pulse lasts one cycle and carries the vector.
- No take follows a masked cycle.
- The handler stays active until a return.

Only the bench's scenarios can show the ordering properties over longer spans:
- edges merging into one take;
- a second request waiting for the handler's return;
- requests caught under the mask and delivered after the exit;
- the same-cycle collisions of enter, return, exit and take;
- the latency of the asynchronous front end.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    typedef enum logic [1:0] {
        ST_READY       = 2'd0,
        ST_HANDLER     = 2'd1,
        ST_SMM_IDLE    = 2'd2,
        ST_SMM_HANDLER = 2'd3
    } nmi_state_e;

    localparam int unsigned NMI_VEC_W = 8;
    localparam logic [NMI_VEC_W-1:0] NMI_VECTOR = 8'h02;

endpackage

// File: rtl/nmi_pin_front.sv
module nmi_pin_front #(
    parameter bit          ASYNC_PIN   = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_q
);

    generate
        if (ASYNC_PIN) begin : g_async
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], pin_raw};
            end
            assign pin_q = chain[SYNC_STAGES-1];
        end else begin : g_sync
            assign pin_q = pin_raw;
        end
    endgenerate

endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_q,
    input  logic consume,
    output logic pending,
    output logic edge_seen
);

    logic pin_prev;

    assign edge_seen = pin_q & ~pin_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev <= 1'b0;
            pending  <= 1'b0;
        end else begin
            pin_prev <= pin_q;
            pending  <= edge_seen | (pending & ~consume);
        end
    end

    // R1: an edge always leaves a request pending
    assert_edge_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> pending);

    // R6: an unconsumed request is never lost
    assert_pending_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !consume) |=> pending);

    // R2: consumption without a new edge clears the request
    assert_consume_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !edge_seen) |=> !pending);

endmodule

// File: rtl/nmi_recog_fsm.sv
module nmi_recog_fsm
    import nmi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pending,
    input  logic                 insn_boundary,
    input  logic                 handler_return,
    input  logic                 smm_enter,
    input  logic                 smm_exit,
    output logic                 consume,
    output logic                 take_nmi,
    output logic [NMI_VEC_W-1:0] take_vector,
    output logic                 handler_active
);

    nmi_state_e state, state_nx;

    assign consume = (state == ST_READY) && insn_boundary && pending && !smm_enter;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: begin
                if (smm_enter)    state_nx = ST_SMM_IDLE;
                else if (consume) state_nx = ST_HANDLER;
            end
            ST_HANDLER: begin
                if (smm_enter)           state_nx = handler_return ? ST_SMM_IDLE : ST_SMM_HANDLER;
                else if (handler_return) state_nx = ST_READY;
            end
            ST_SMM_IDLE: begin
                if (smm_exit) state_nx = ST_READY;
            end
            ST_SMM_HANDLER: begin
                if (handler_return && smm_exit) state_nx = ST_READY;
                else if (handler_return)        state_nx = ST_SMM_IDLE;
                else if (smm_exit)              state_nx = ST_HANDLER;
            end
            default: state_nx = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_nmi    <= 1'b0;
            take_vector <= '0;
        end else begin
            take_nmi    <= consume;
            take_vector <= consume ? NMI_VECTOR : '0;
        end
    end

    assign handler_active = (state == ST_HANDLER) || (state == ST_SMM_HANDLER);

    // R2: a take follows only a boundary with a request pending
    assert_take_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> ($past(pending) && $past(insn_boundary)));

    // R2: the take pulse is one cycle long
    assert_take_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> !take_nmi);

    // R3: vector accompanies the take and is zero otherwise
    assert_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi ? (take_vector == NMI_VECTOR) : (take_vector == '0));

    // R4: take starts a handler
    assert_take_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> handler_active);

    // R4: handler stays active until a return
    assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_active && !handler_return) |=> handler_active);

    // R7: no take after a cycle spent masked
    assert_smm_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SMM_IDLE) || (state == ST_SMM_HANDLER) || smm_enter) |=> !take_nmi);

endmodule

// File: rtl/nmi_recognizer.sv
module nmi_recognizer
    import nmi_pkg::*;
#(
    parameter bit          ASYNC_PIN   = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nmi_line,
    input  logic                 insn_boundary,
    input  logic                 handler_return,
    input  logic                 smm_enter,
    input  logic                 smm_exit,
    output logic                 take_nmi,
    output logic [NMI_VEC_W-1:0] take_vector,
    output logic                 handler_active
);

    logic pin_q;
    logic pending;
    logic edge_seen;
    logic consume;

    nmi_pin_front #(
        .ASYNC_PIN  (ASYNC_PIN),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_raw(nmi_line),
        .pin_q  (pin_q)
    );

    nmi_edge_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_q    (pin_q),
        .consume  (consume),
        .pending  (pending),
        .edge_seen(edge_seen)
    );

    nmi_recog_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pending       (pending),
        .insn_boundary (insn_boundary),
        .handler_return(handler_return),
        .smm_enter     (smm_enter),
        .smm_exit      (smm_exit),
        .consume       (consume),
        .take_nmi      (take_nmi),
        .take_vector   (take_vector),
        .handler_active(handler_active)
    );

    // R10: a take with a simultaneous edge leaves a request pending
    assert_take_and_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && edge_seen) |=> pending);

endmodule

// File: tb/nmi_recognizer_test.sv
module nmi_recognizer_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_line = 1'b0, insn_boundary = 1'b0, handler_return = 1'b0;
    logic smm_enter = 1'b0, smm_exit = 1'b0;
    logic take_nmi, handler_active;
    logic [7:0] take_vector;

    logic a_line = 1'b0, a_bnd = 1'b0;
    logic a_take, a_active;
    logic [7:0] a_vec;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_recognizer #(.ASYNC_PIN(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .nmi_line(nmi_line), .insn_boundary(insn_boundary),
        .handler_return(handler_return), .smm_enter(smm_enter), .smm_exit(smm_exit),
        .take_nmi(take_nmi), .take_vector(take_vector), .handler_active(handler_active));

    nmi_recognizer #(.ASYNC_PIN(1'b1), .SYNC_STAGES(2)) uut_async (
        .clk(clk), .rst_n(rst_n), .nmi_line(a_line), .insn_boundary(a_bnd),
        .handler_return(1'b0), .smm_enter(1'b0), .smm_exit(1'b0),
        .take_nmi(a_take), .take_vector(a_vec), .handler_active(a_active));

    // {line, boundary, return, smm_enter, smm_exit, exp_take, exp_active}
    localparam logic [6:0] VEC [0:NVEC-1] = '{
        7'b0000000, 7'b1000000, 7'b0000000, 7'b0100011, 7'b0100001, // R1 R2 R4
        7'b1000001, 7'b1100001, 7'b0010000, 7'b0100011, 7'b0010000, // R5
        7'b0100000, 7'b1000000, 7'b0000000, 7'b1000000, 7'b0100011, // R6
        7'b0010000, 7'b0100000,
        7'b0001000, 7'b1100000, 7'b0100000, 7'b0100100, 7'b0100011, // R7 R8
        7'b0010000, 7'b1000000, 7'b0101000, 7'b0000100, 7'b0100011, // R7 R8
        7'b0001001, 7'b0010000, 7'b1100000, 7'b0100000, 7'b0000100, // R9
        7'b0100011, 7'b0001001, 7'b0000101, 7'b0010000,             // R9
        7'b1000000, 7'b0000000, 7'b1100011, 7'b0010000, 7'b0100011, // R10
        7'b0010000
    };

    function automatic string tag_of(int i);
        if (i <= 4)  return "R2";
        if (i <= 10) return "R5";
        if (i <= 16) return "R6";
        if (i <= 26) return "R8";
        if (i <= 35) return "R9";
        return "R10";
    endfunction

    task automatic check(string tag, int actual, int expected, string what);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, actual, expected, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int first_take;
        int n_take;
        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12", take_nmi, 0, "take in reset");
        check("R12", handler_active, 0, "active in reset");
        check("R12", take_vector, 0, "vector in reset");
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11(single-clock pulse)
        for (int i = 0; i < NVEC; i++) begin
            {nmi_line, insn_boundary, handler_return, smm_enter, smm_exit} = VEC[i][6:2];
            @(posedge clk);
            @(negedge clk);
            check(tag_of(i), take_nmi, VEC[i][1], "take");
            check("R4", handler_active, VEC[i][0], "handler_active");
            check("R3", take_vector, VEC[i][1] ? 8'h02 : 8'h00, "vector");
        end
        {nmi_line, insn_boundary, handler_return, smm_enter, smm_exit} = '0;

        // R1: line held high makes no second request
        nmi_line = 1'b1;
        @(posedge clk); @(negedge clk);
        insn_boundary = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", take_nmi, 1, "take from held line");
        insn_boundary = 1'b0; handler_return = 1'b1;
        @(posedge clk); @(negedge clk);
        handler_return = 1'b0; insn_boundary = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", take_nmi, 0, "no take from level");
        insn_boundary = 1'b0; nmi_line = 1'b0;

        // R11: asynchronous line low two clocks, then high two clocks
        a_bnd = 1'b1;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        first_take = 0;
        n_take = 0;
        a_line = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 2) a_line = 1'b0;
            if (a_take) begin
                n_take++;
                if (first_take == 0) first_take = k;
            end
        end
        check("R11", n_take, 1, "async take count");
        check("R11", first_take, 4, "async take latency");
        check("R11", a_vec, 0, "async vector idle");
        a_bnd = 1'b0;

        // R12: reset during an active handler
        nmi_line = 1'b1;
        @(posedge clk); @(negedge clk);
        nmi_line = 1'b0;
        insn_boundary = 1'b1;
        @(posedge clk); @(negedge clk);
        insn_boundary = 1'b0;
        check("R4", handler_active, 1, "active before reset");
        nmi_line = 1'b1;
        @(posedge clk); @(negedge clk);
        nmi_line = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R12", handler_active, 0, "active cleared by reset");
        rst_n = 1'b1;
        insn_boundary = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R12", take_nmi, 0, "pending cleared by reset");
        check("R12", handler_active, 0, "still idle after reset");
        insn_boundary = 1'b0;

        finish_run();
    end

endmodule